// File: doc/BRIEF.md
# Hit Flag Register with Trigger Multiplicity

This block keeps one hit flag per detector channel. A rising edge on a channel's discriminator line sets that channel's flag. The flag then clears by itself when the circular sample memory's write pointer passes cell zero for the second time after the most recent hit. A flag therefore covers between one and two full write passes. Each new hit on the channel restarts this window. The flags stay visible on a parallel output, so that after the write phase the configuration link can fetch them. A clear strobe at the start of readout empties all of them at once.

Each hit also starts a pulse of fixed length on its channel. The pulses of all channels are combined into a trigger output (their OR) and a multiplicity count (the number of pulses active in the same cycle). This count stands in for the analogue sum.

Discriminator lines are asynchronous, so they pass through a two-stage synchroniser. Only a rising edge counts as a hit. The memory-wrap and readout-clear strobes are synchronous single-cycle inputs.

Top module: `hit_mult_top`

## Requirements
- R1: While reset is asserted and on the first cycle after reset, `hitFlags` is all zero, `trigOut` is 0 and `multCount` is 0.
- R2: A rising edge on `discIn[i]` sets `hitFlags[i]` to 1. The flag is visible after the third rising clock edge that samples the new level.
- R3: A discriminator line held high produces exactly one hit. Its pulse lasts `PULSE_CYC` cycles, and a flag that later expires is not set again while the line stays high.
- R4: A set flag survives the first `cellZeroCross` strobe after its last hit and clears on the second. Crossings while the flag is clear have no effect.
- R5: A new hit on a channel whose flag is already set restarts the count, so two further crossings are needed to clear it.
- R6: When a hit and a `cellZeroCross` strobe fall on the same cycle, the hit wins: the flag stays 1 and its crossing count restarts from zero.
- R7: `readoutClr` clears every flag and crossing count on the next edge. It overrides a hit in the same cycle, but it does not cut short running pulses.
- R8: Each hit drives the channel's pulse high for exactly `PULSE_CYC` (default 2) cycles, starting in the same cycle as the flag. `trigOut` is the OR of all channel pulses.
- R9: `multCount` equals the number of channels whose pulse is active in that cycle. The range is 0 to `NUM_CH`, in `$clog2(NUM_CH+1)` bits (7 bits by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| discIn | input | NUM_CH | Asynchronous discriminator levels, one per channel |
| cellZeroCross | input | 1 | One-cycle strobe each time the write pointer passes cell zero |
| readoutClr | input | 1 | One-cycle strobe at readout start; clears all flags |
| hitFlags | output | NUM_CH | Per-channel hit flags |
| trigOut | output | 1 | OR of all channel pulses |
| multCount | output | $clog2(NUM_CH+1) | Number of channel pulses active this cycle |

## Verification
The bench goes after several corner cases:
- **Same-cycle hit and crossing.** A design that let the crossing win would drop a flag that had already seen one crossing.
- **Re-hit before expiry.** A design that did not restart the count would clear the flag one crossing early.
- **Level held high across expiry.** Level-sensitive detection would set the flag again and stretch the pulse.
- **Clear on the same cycle as a hit.** A design with the wrong precedence would leave a flag standing after readout starts.
- **Many channels firing together.** A narrow or truncating counter would report the wrong multiplicity.

Beyond these directed cases, random toggling across all channels is compared every cycle with a reference model in the bench.

// File: rtl/hit_mult_pkg.sv
package hit_mult_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic crossStb;  // write pointer passed cell zero this cycle
    logic clrStb;    // readout begins: empty every flag
  } strobe_t;

endpackage

// File: rtl/hit_mult_ctrl.sv
module hit_mult_ctrl
  import hit_mult_pkg::*;
#(
  parameter int NUM_CH    = 64,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] discIn,
  input  logic              cellZeroCross,
  input  logic              readoutClr,
  output logic [NUM_CH-1:0] hitStb,
  output strobe_t           strb
);

  // Synchroniser chain, one vector per stage
  logic [NUM_CH-1:0] syncQ [SYNC_DEPTH];
  logic [NUM_CH-1:0] lastQ;

  genvar s;
  generate
    for (s = 0; s < SYNC_DEPTH; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncQ[s] <= '0;
        end else if (s == 0) begin
          syncQ[s] <= discIn;
        end else begin
          syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= '0;
    else       lastQ <= syncQ[SYNC_DEPTH-1];
  end

  // Rising edge only: a held level yields one strobe
  assign hitStb = syncQ[SYNC_DEPTH-1] & ~lastQ;

  always_comb begin
    strb.crossStb = cellZeroCross;
    strb.clrStb   = readoutClr;
  end

  AST_ONE_HIT_PER_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (hitStb & $past(hitStb)) == '0); // R3

endmodule

// File: rtl/hit_mult_dp.sv
module hit_mult_dp
  import hit_mult_pkg::*;
#(
  parameter int NUM_CH      = 64,
  parameter int PULSE_CYC   = 2,
  parameter int CROSS_LIMIT = 2,
  localparam int MW = $clog2(NUM_CH + 1),
  localparam int PW = $clog2(PULSE_CYC + 1),
  localparam int CW = $clog2(CROSS_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] hitStb,
  input  strobe_t           strb,
  output logic [NUM_CH-1:0] flagQ,
  output logic [NUM_CH-1:0] pulseOn,
  output logic              trigOut,
  output logic [MW-1:0]     multCount
);

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_ch
      logic          flagR;
      logic [CW-1:0] crossCnt;
      logic [PW-1:0] pulseCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flagR    <= 1'b0;
          crossCnt <= '0;
        end else if (strb.clrStb) begin
          flagR    <= 1'b0;
          crossCnt <= '0;
        end else if (hitStb[i]) begin
          flagR    <= 1'b1;
          crossCnt <= '0;
        end else if (strb.crossStb && flagR) begin
          if (crossCnt == CW'(CROSS_LIMIT - 1)) begin
            flagR    <= 1'b0;
            crossCnt <= '0;
          end else begin
            crossCnt <= crossCnt + 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              pulseCnt <= '0;
        else if (hitStb[i])     pulseCnt <= PW'(PULSE_CYC);
        else if (pulseCnt != 0) pulseCnt <= pulseCnt - 1'b1;
      end

      assign flagQ[i]   = flagR;
      assign pulseOn[i] = (pulseCnt != '0);
    end
  endgenerate

  always_comb begin
    multCount = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      multCount = multCount + MW'(pulseOn[k]);
    end
  end

  assign trigOut = |pulseOn;

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStb |=> (flagQ == '0)); // R7
  AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    ((|hitStb) && !strb.clrStb) |=> ((flagQ & $past(hitStb)) == $past(hitStb))); // R2
  AST_NO_SPONTANEOUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.crossStb && !strb.clrStb) |=> (($past(flagQ) & ~flagQ) == '0)); // R4
  AST_TRIG_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    trigOut == (multCount != '0)); // R8

endmodule

// File: rtl/hit_mult_top.sv
module hit_mult_top
  import hit_mult_pkg::*;
#(
  parameter int NUM_CH      = 64,
  parameter int PULSE_CYC   = 2,
  parameter int CROSS_LIMIT = 2,
  parameter int SYNC_DEPTH  = 2,
  localparam int MW = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] discIn,
  input  logic              cellZeroCross,
  input  logic              readoutClr,
  output logic [NUM_CH-1:0] hitFlags,
  output logic              trigOut,
  output logic [MW-1:0]     multCount
);

  logic [NUM_CH-1:0] hitStb;
  logic [NUM_CH-1:0] pulseOn;
  strobe_t           strb;

  hit_mult_ctrl #(
    .NUM_CH    (NUM_CH),
    .SYNC_DEPTH(SYNC_DEPTH)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .discIn       (discIn),
    .cellZeroCross(cellZeroCross),
    .readoutClr   (readoutClr),
    .hitStb       (hitStb),
    .strb         (strb)
  );

  hit_mult_dp #(
    .NUM_CH     (NUM_CH),
    .PULSE_CYC  (PULSE_CYC),
    .CROSS_LIMIT(CROSS_LIMIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .hitStb   (hitStb),
    .strb     (strb),
    .flagQ    (hitFlags),
    .pulseOn  (pulseOn),
    .trigOut  (trigOut),
    .multCount(multCount)
  );

endmodule

// File: tb/sim_hit_mult_top.sv
module sim_hit_mult_top;
  localparam int NCH = 64;
  localparam int PCY = 2;
  localparam int MW  = 7;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] discIn = '0;
  logic           cellZeroCross = 1'b0;
  logic           readoutClr = 1'b0;
  logic [NCH-1:0] hitFlags;
  logic           trigOut;
  logic [MW-1:0]  multCount;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  hit_mult_top u0 (
    .clk(clk), .rstN(rstN), .discIn(discIn), .cellZeroCross(cellZeroCross),
    .readoutClr(readoutClr), .hitFlags(hitFlags), .trigOut(trigOut),
    .multCount(multCount)
  );

  // Reference model built from the requirements
  logic [NCH-1:0] m1 = '0, m2 = '0, m3 = '0, mFlag = '0;
  int mCross [NCH];
  int mPulse [NCH];

  always @(posedge clk) begin
    logic [NCH-1:0] edgeV;
    if (!rstN) begin
      m1 = '0; m2 = '0; m3 = '0; mFlag = '0;
      for (int c = 0; c < NCH; c++) begin mCross[c] = 0; mPulse[c] = 0; end
    end else begin
      edgeV = m2 & ~m3;
      m3 = m2; m2 = m1; m1 = discIn;
      for (int c = 0; c < NCH; c++) begin
        if (readoutClr) begin mFlag[c] = 1'b0; mCross[c] = 0; end
        else if (edgeV[c]) begin mFlag[c] = 1'b1; mCross[c] = 0; end
        else if (cellZeroCross && mFlag[c]) begin
          mCross[c]++;
          if (mCross[c] == 2) begin mFlag[c] = 1'b0; mCross[c] = 0; end
        end
        if (edgeV[c]) mPulse[c] = PCY;
        else if (mPulse[c] > 0) mPulse[c]--;
      end
    end
  end

  function automatic int expMult();
    int n = 0;
    for (int c = 0; c < NCH; c++) if (mPulse[c] > 0) n++;
    return n;
  endfunction

  task automatic chk(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cmpModel(string tagF, string tagT, string tagM);
    chk(tagF, hitFlags, mFlag);
    chk(tagT, NCH'(trigOut), NCH'(expMult() != 0));
    chk(tagM, NCH'(multCount), NCH'(expMult()));
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic crossPulse();
    cellZeroCross = 1'b1; tick(); cellZeroCross = 1'b0; tick();
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed = 12345;
    void'($urandom(seed));
    ticks(3);
    chk("R1 flags in reset", hitFlags, '0);
    chk("R1 trig in reset", NCH'(trigOut), '0);
    rstN = 1'b1; tick();
    chk("R1 flags after reset", hitFlags, '0);
    chk("R1 mult after reset", NCH'(multCount), '0);

    // R2 / R8: single hit latency and pulse width
    discIn[3] = 1'b1; tick(); tick();
    chk("R2 not yet set", hitFlags, '0);
    tick();
    chk("R2 flag set", hitFlags, 64'h8);
    chk("R8 trig high c1", NCH'(trigOut), 64'd1);
    tick();
    chk("R8 trig high c2", NCH'(trigOut), 64'd1);
    tick();
    chk("R8 trig low after width", NCH'(trigOut), 64'd0);

    // R4: survive first crossing, clear on second; R3 level held high
    crossPulse();
    chk("R4 kept after first cross", hitFlags, 64'h8);
    crossPulse();
    chk("R4 cleared on second cross", hitFlags, '0);
    ticks(4);
    chk("R3 held level no rehit", hitFlags, '0);
    chk("R3 held level no pulse", NCH'(trigOut), '0);
    crossPulse(); crossPulse();
    chk("R4 cross on clear flag", hitFlags, '0);
    discIn[3] = 1'b0; ticks(4);

    // R5: rehit restarts retention
    discIn[7] = 1'b1; ticks(3); discIn[7] = 1'b0;
    crossPulse();
    discIn[7] = 1'b1; ticks(4);
    crossPulse();
    chk("R5 kept after rehit plus one cross", hitFlags, 64'h80);
    crossPulse();
    chk("R5 cleared after two more", hitFlags, '0);
    discIn[7] = 1'b0; ticks(4);

    // R6: hit and crossing same cycle, flag already one crossing in
    discIn[5] = 1'b1; ticks(4); discIn[5] = 1'b0;
    crossPulse(); ticks(3);
    discIn[5] = 1'b1; tick(); tick();
    cellZeroCross = 1'b1; tick(); cellZeroCross = 1'b0;
    chk("R6 hit wins over cross", hitFlags, 64'h20);
    tick();
    crossPulse();
    chk("R6 count restarted", hitFlags, 64'h20);
    crossPulse();
    chk("R6 clear after two", hitFlags, '0);
    discIn[5] = 1'b0; ticks(4);

    // R7: clear overrides same-cycle hit; R9 multiplicity all channels
    discIn = '1; tick(); tick();
    readoutClr = 1'b1; tick(); readoutClr = 1'b0;
    chk("R7 clear beats hit", hitFlags, '0);
    chk("R9 all channels counted", NCH'(multCount), 64'd64);
    chk("R7 pulse survives clear", NCH'(trigOut), 64'd1);
    tick();
    chk("R9 second cycle count", NCH'(multCount), 64'd64);
    tick();
    chk("R9 count back to zero", NCH'(multCount), 64'd0);
    discIn = '0; ticks(4);
    discIn[0] = 1'b1; discIn[9] = 1'b1; discIn[40] = 1'b1; ticks(3);
    chk("R9 three channels", NCH'(multCount), 64'd3);
    discIn = '0; ticks(4);

    // Random phase against the model
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if ($urandom_range(0, 3) == 0) begin
        int ch = $urandom_range(0, NCH - 1);
        discIn[ch] = ~discIn[ch];
      end
      cellZeroCross = ($urandom_range(0, 11) == 0);
      readoutClr    = ($urandom_range(0, 299) == 0);
      tick();
      cmpModel("R4 random flags", "R8 random trig", "R9 random mult");
    end
    cellZeroCross = 1'b0; readoutClr = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule